// File: doc/BRIEF.md
# Grouped Interrupt Status and Enable Controller

This block gathers event pulses from six functional groups of a serial communications controller: two timers, the transmit machine, the modem lines, seven receive-machine conditions, the receive FIFO and the transmit FIFO. Each pulse sets a sticky status bit. Where a group has several bits, each bit has its own enable. Each group is folded into one bit of a group summary register. A group enable register masks those summary bits, and the masked bits are ORed into a single interrupt request line. An identification register reports the most urgent pending group as a 3-bit code.

Software reaches the block through a plain register bus: a 4-bit address, one-cycle read and write strobes, 8-bit write data and combinational read data. The bus carries single register accesses with no streaming data, so it has no valid/ready handshake. A read or write takes effect at the clock edge on which its strobe is high. Each group is cleared in its own way. Some status registers clear when read. Some clear by writing 0 to the chosen bits. Two pulse inputs stand for data moving through the FIFOs and clear the matching flags as a side effect. An identification read clears the transmit FIFO flag. A command register clears every source at once.

Top module: `irq_group_ctrl`

## Requirements
- R1: Group summary register (address 0, bits 5..0) has bit 5 = timers, bit 4 = transmit machine, bit 3 = modem, bit 2 = receive machine, bit 1 = transmit FIFO, bit 0 = receive FIFO. A group bit is the OR of its status bits, each ANDed with its per-bit enable. The receive FIFO, transmit FIFO and transmit machine have no per-bit enable.
- R2: `irq_o` is the OR of the group summary bits ANDed with the group enable register (address 1, same bit positions). A 0 enable bit masks its group.
- R3: Identification register (address 2) reads {pending, 4'b0, code}. code is the index of the highest-numbered enabled pending group. When nothing is pending the register reads 0.
- R4: Timer status (address 3, bits 1..0; enable at address 4) clears when read.
- R5: Modem status (address 5, bits 3..0; enable at address 6) clears when read. Writing it clears each bit written as 0 and keeps each bit written as 1.
- R6: Receive status (address 7): bits 7..1 are receive-machine flags, with enables at address 8 bits 7..1. A read clears them, and so does writing 0 to a bit.
- R7: Receive status bit 0 is the receive FIFO flag. Writing 0 to it clears it, and so does a pulse on `rxfifo_rd`. A read of address 7 leaves it unchanged.
- R8: Transmit FIFO flag (address 9 bit 0, read-only) clears on a pulse of `txfifo_wr`. It also clears on a read of address 2, but only when that read reports code 1.
- R9: Transmit machine flag (address 9 bit 1, read-only) clears on a pulse of `txfifo_wr`.
- R10: Writing 1 to bit 0 of the command register (address 10) clears every status bit. Enables are kept.
- R11: An event pulse that arrives in the same cycle as any clear of its bit leaves the bit set.
- R12: After reset, all status and enable registers are 0 and `irq_o` is low.
- R13: Enable registers read back the value written. Unmapped addresses and address 10 read 0. Writes to read-only addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ev_timer | input | 2 | Timer event pulses |
| ev_txm | input | 1 | Transmit machine event pulse |
| ev_modem | input | 4 | Modem line change pulses |
| ev_rxm | input | 7 | Receive machine event pulses (status bits 7..1) |
| ev_rxfifo | input | 1 | Receive FIFO event pulse |
| ev_txfifo | input | 1 | Transmit FIFO event pulse |
| txfifo_wr | input | 1 | A character was written to the transmit FIFO |
| rxfifo_rd | input | 1 | A character was read from the receive FIFO |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives single-group events, then groups with only some per-bit enables set, then several groups at once under different group enable masks. Single-group events show that each group lands on its own summary bit. Partial enables separate per-bit masking from group masking. Overlapping groups expose the priority order in the identification code. Each clear path is then used while a neighbouring source is also pending: an identification read with a higher group pending, a receive status read with the FIFO flag set, and selective zero-writes. These cases tell a clear of the right bits apart from one that reaches too far. Event pulses that land on the same edge as a clear show whether set wins over clear.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int NREG  = 11;
  localparam int NGRP  = 6;
  localparam int IDW   = 3;
  localparam int TMR_W = 2;
  localparam int MDM_W = 4;
  localparam int RXM_W = 7;
  localparam int RX_W  = RXM_W + 1;
  localparam int TX_W  = 2;

  // register addresses
  localparam int A_GST   = 0;
  localparam int A_GEN   = 1;
  localparam int A_IDENT = 2;
  localparam int A_TST   = 3;
  localparam int A_TEN   = 4;
  localparam int A_MST   = 5;
  localparam int A_MEN   = 6;
  localparam int A_RST   = 7;
  localparam int A_REN   = 8;
  localparam int A_TXS   = 9;
  localparam int A_CMD   = 10;

  // group positions in the summary register (priority: higher wins)
  localparam int G_RXF = 0;
  localparam int G_TXF = 1;
  localparam int G_RXM = 2;
  localparam int G_MDM = 3;
  localparam int G_TXM = 4;
  localparam int G_TMR = 5;
endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec #(
  parameter int AW   = 4,
  parameter int NREG = 11
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == AW'(i));
  end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] rd_clr,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ext_clr,
  input  logic         clr_all,
  output logic [W-1:0] stat
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic clr_b;
    assign clr_b = rd_clr[i] | (wr_stb & ~wdata[i]) | ext_clr[i] | clr_all;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat[i] <= 1'b0;
      else if (ev[i])  stat[i] <= 1'b1;   // set wins over any clear
      else if (clr_b)  stat[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_stb) q <= d;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 6,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          pend,
  output logic [CW-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) code = CW'(i);
    end
  end
  assign pend = |req;
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_group_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [TMR_W-1:0] ev_timer,
  input  logic             ev_txm,
  input  logic [MDM_W-1:0] ev_modem,
  input  logic [RXM_W-1:0] ev_rxm,
  input  logic             ev_rxfifo,
  input  logic             ev_txfifo,
  input  logic             txfifo_wr,
  input  logic             rxfifo_rd,
  output logic             irq_o
);
  logic [NREG-1:0]  hit;
  logic [NGRP-1:0]  ger_q, grp, grp_req;
  logic [TMR_W-1:0] tmr_st, tmr_en;
  logic [MDM_W-1:0] mdm_st, mdm_en;
  logic [RX_W-1:0]  rx_st;
  logic [RXM_W-1:0] rx_en;
  logic [TX_W-1:0]  tx_st;
  logic             pend_w;
  logic [IDW-1:0]   code_w;
  logic             clr_all, ident_clr;

  irq_bus_dec #(.AW(AW), .NREG(NREG)) u_dec (.addr(addr), .hit(hit));

  assign clr_all   = wr_en & hit[A_CMD] & wdata[0];
  assign ident_clr = rd_en & hit[A_IDENT] & pend_w & (code_w == IDW'(G_TXF));

  // enable registers
  irq_en_reg #(.W(NGRP)) u_ger (.clk(clk), .rst_n(rst_n),
    .wr_stb(wr_en & hit[A_GEN]), .d(wdata[NGRP-1:0]), .q(ger_q));
  irq_en_reg #(.W(TMR_W)) u_ten (.clk(clk), .rst_n(rst_n),
    .wr_stb(wr_en & hit[A_TEN]), .d(wdata[TMR_W-1:0]), .q(tmr_en));
  irq_en_reg #(.W(MDM_W)) u_men (.clk(clk), .rst_n(rst_n),
    .wr_stb(wr_en & hit[A_MEN]), .d(wdata[MDM_W-1:0]), .q(mdm_en));
  irq_en_reg #(.W(RXM_W)) u_ren (.clk(clk), .rst_n(rst_n),
    .wr_stb(wr_en & hit[A_REN]), .d(wdata[RX_W-1:1]), .q(rx_en));

  // status banks
  irq_src_bank #(.W(TMR_W)) u_tmr (.clk(clk), .rst_n(rst_n), .ev(ev_timer),
    .rd_clr({TMR_W{rd_en & hit[A_TST]}}), .wr_stb(1'b0), .wdata('0),
    .ext_clr('0), .clr_all(clr_all), .stat(tmr_st));

  irq_src_bank #(.W(MDM_W)) u_mdm (.clk(clk), .rst_n(rst_n), .ev(ev_modem),
    .rd_clr({MDM_W{rd_en & hit[A_MST]}}), .wr_stb(wr_en & hit[A_MST]),
    .wdata(wdata[MDM_W-1:0]), .ext_clr('0), .clr_all(clr_all), .stat(mdm_st));

  irq_src_bank #(.W(RX_W)) u_rx (.clk(clk), .rst_n(rst_n),
    .ev({ev_rxm, ev_rxfifo}),
    .rd_clr({{RXM_W{rd_en & hit[A_RST]}}, 1'b0}), .wr_stb(wr_en & hit[A_RST]),
    .wdata(wdata[RX_W-1:0]), .ext_clr({{RXM_W{1'b0}}, rxfifo_rd}),
    .clr_all(clr_all), .stat(rx_st));

  // tx bank: bit 0 transmit FIFO, bit 1 transmit machine
  irq_src_bank #(.W(TX_W)) u_tx (.clk(clk), .rst_n(rst_n),
    .ev({ev_txm, ev_txfifo}), .rd_clr('0), .wr_stb(1'b0), .wdata('0),
    .ext_clr({txfifo_wr, txfifo_wr | ident_clr}),
    .clr_all(clr_all), .stat(tx_st));

  // group summary
  assign grp[G_RXF] = rx_st[0];
  assign grp[G_TXF] = tx_st[0];
  assign grp[G_RXM] = |(rx_st[RX_W-1:1] & rx_en);
  assign grp[G_MDM] = |(mdm_st & mdm_en);
  assign grp[G_TXM] = tx_st[1];
  assign grp[G_TMR] = |(tmr_st & tmr_en);

  assign grp_req = grp & ger_q;
  assign irq_o   = |grp_req;

  irq_prio_enc #(.N(NGRP)) u_prio (.req(grp_req), .pend(pend_w), .code(code_w));

  // read mux
  assign rdata = ({DW{hit[A_GST]}}   & DW'(grp))
               | ({DW{hit[A_GEN]}}   & DW'(ger_q))
               | ({DW{hit[A_IDENT]}} & {pend_w, {(DW-1-IDW){1'b0}}, code_w})
               | ({DW{hit[A_TST]}}   & DW'(tmr_st))
               | ({DW{hit[A_TEN]}}   & DW'(tmr_en))
               | ({DW{hit[A_MST]}}   & DW'(mdm_st))
               | ({DW{hit[A_MEN]}}   & DW'(mdm_en))
               | ({DW{hit[A_RST]}}   & DW'(rx_st))
               | ({DW{hit[A_REN]}}   & DW'({rx_en, 1'b0}))
               | ({DW{hit[A_TXS]}}   & DW'(tx_st))
               | ({DW{hit[A_CMD]}}   & {DW{1'b0}});
endmodule

// File: rtl/irq_group_chk.sv
module irq_group_chk
  import irq_group_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    wdata,
  input logic [TMR_W-1:0] ev_timer,
  input logic             ev_txm,
  input logic [MDM_W-1:0] ev_modem,
  input logic [RXM_W-1:0] ev_rxm,
  input logic             ev_rxfifo,
  input logic             ev_txfifo,
  input logic             txfifo_wr,
  input logic             rxfifo_rd,
  input logic             irq_o,
  input logic             pend_w,
  input logic [NGRP-1:0]  ger_q,
  input logic [TMR_W-1:0] tmr_st,
  input logic [MDM_W-1:0] mdm_st,
  input logic [RX_W-1:0]  rx_st,
  input logic [TX_W-1:0]  tx_st
);
  logic no_ev;
  assign no_ev = (ev_timer == '0) && !ev_txm && (ev_modem == '0) &&
                 (ev_rxm == '0) && !ev_rxfifo && !ev_txfifo;

  // R2
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ger_q == '0) |-> !irq_o);

  // R3
  a_r3_pend_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == pend_w);

  // R4
  a_r4_tmr_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(A_TST) && ev_timer == '0) |=> (tmr_st == '0));

  // R7
  a_r7_rxfifo_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == AW'(A_RST) && !rxfifo_rd && rx_st[0]) |=> rx_st[0]);

  // R8, R9
  a_r8_txfifo_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (txfifo_wr && !ev_txfifo && !ev_txm) |=> (tx_st == '0));

  // R10
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(A_CMD) && wdata[0] && no_ev) |=>
      (tmr_st == '0 && mdm_st == '0 && rx_st == '0 && tx_st == '0));

  // R11
  a_r11_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_modem != '0) |=> ((mdm_st & $past(ev_modem)) == $past(ev_modem)));
endmodule

bind irq_group_ctrl irq_group_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .ev_timer(ev_timer), .ev_txm(ev_txm), .ev_modem(ev_modem),
  .ev_rxm(ev_rxm), .ev_rxfifo(ev_rxfifo), .ev_txfifo(ev_txfifo),
  .txfifo_wr(txfifo_wr), .rxfifo_rd(rxfifo_rd), .irq_o(irq_o),
  .pend_w(pend_w), .ger_q(ger_q), .tmr_st(tmr_st), .mdm_st(mdm_st),
  .rx_st(rx_st), .tx_st(tx_st)
);

// File: tb/irq_group_ctrl_tb_top.sv
module irq_group_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ev_timer = '0;
  logic       ev_txm = 1'b0;
  logic [3:0] ev_modem = '0;
  logic [6:0] ev_rxm = '0;
  logic       ev_rxfifo = 1'b0, ev_txfifo = 1'b0;
  logic       txfifo_wr = 1'b0, rxfifo_rd = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_group_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ev_timer(ev_timer), .ev_txm(ev_txm),
    .ev_modem(ev_modem), .ev_rxm(ev_rxm), .ev_rxfifo(ev_rxfifo),
    .ev_txfifo(ev_txfifo), .txfifo_wr(txfifo_wr), .rxfifo_rd(rxfifo_rd),
    .irq_o(irq_o));

  // reference model state
  logic [1:0] m_tmr = '0, m_ten = '0;
  logic [3:0] m_mdm = '0, m_men = '0;
  logic [7:0] m_rx  = '0;
  logic [6:0] m_ren = '0;
  logic       m_txf = 1'b0, m_txm = 1'b0;
  logic [5:0] m_ger = '0;

  function automatic logic [5:0] m_groups();
    logic [5:0] g;
    g[5] = (m_tmr & m_ten) != 0;
    g[4] = m_txm;
    g[3] = (m_mdm & m_men) != 0;
    g[2] = (m_rx[7:1] & m_ren) != 0;
    g[1] = m_txf;
    g[0] = m_rx[0];
    return g;
  endfunction

  function automatic logic [7:0] m_ident();
    logic [5:0] r;
    r = m_groups() & m_ger;
    for (int i = 5; i >= 0; i--)
      if (r[i]) return 8'h80 | 8'(i);
    return 8'h00;
  endfunction

  function automatic logic m_irq();
    return (m_groups() & m_ger) != 0;
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd0:  return {2'b00, m_groups()};
      4'd1:  return {2'b00, m_ger};
      4'd2:  return m_ident();
      4'd3:  return {6'b0, m_tmr};
      4'd4:  return {6'b0, m_ten};
      4'd5:  return {4'b0, m_mdm};
      4'd6:  return {4'b0, m_men};
      4'd7:  return m_rx;
      4'd8:  return {m_ren, 1'b0};
      4'd9:  return {6'b0, m_txm, m_txf};
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_step();
    bit call = wr_en && addr == 4'd10 && wdata[0];
    bit idclr = rd_en && addr == 4'd2 && m_ident() == 8'h81;
    logic [1:0] nt = m_tmr;
    logic [3:0] nm = m_mdm;
    logic [7:0] nr = m_rx;
    logic nf = m_txf, nx = m_txm;
    if (rd_en && addr == 4'd3) nt = '0;
    if (rd_en && addr == 4'd5) nm = '0;
    if (wr_en && addr == 4'd5) nm = nm & wdata[3:0];
    if (rd_en && addr == 4'd7) nr[7:1] = '0;
    if (wr_en && addr == 4'd7) nr = nr & wdata;
    if (rxfifo_rd) nr[0] = 1'b0;
    if (txfifo_wr) begin nf = 1'b0; nx = 1'b0; end
    if (idclr) nf = 1'b0;
    if (call) begin nt = '0; nm = '0; nr = '0; nf = 1'b0; nx = 1'b0; end
    m_tmr = nt | ev_timer;
    m_mdm = nm | ev_modem;
    m_rx  = nr | {ev_rxm, ev_rxfifo};
    m_txf = nf | ev_txfifo;
    m_txm = nx | ev_txm;
    if (wr_en && addr == 4'd1) m_ger = wdata[5:0];
    if (wr_en && addr == 4'd4) m_ten = wdata[1:0];
    if (wr_en && addr == 4'd6) m_men = wdata[3:0];
    if (wr_en && addr == 4'd8) m_ren = wdata[7:1];
  endtask

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: inputs already driven after a falling edge
  task automatic cyc(input string tag);
    #1;
    check(tag, "irq",   {7'b0, irq_o}, {7'b0, m_irq()});
    check(tag, "rdata", rdata, m_read(addr));
    @(posedge clk);
    if (rst_n) m_step();
    @(negedge clk);
    wr_en = 0; rd_en = 0; wdata = '0; ev_timer = '0; ev_txm = 0;
    ev_modem = '0; ev_rxm = '0; ev_rxfifo = 0; ev_txfifo = 0;
    txfifo_wr = 0; rxfifo_rd = 0;
  endtask

  task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; cyc(tag);
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    addr = a; rd_en = 1; cyc(tag);
  endtask

  task automatic peek(input string tag, input logic [3:0] a);
    addr = a; cyc(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    peek("R12", 4'd0);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state of every register
    for (int a = 0; a < 11; a++) peek("R12", 4'(a));

    // R13 enable readback, unmapped / read-only addresses
    wr("R13", 4'd1, 8'hFF); peek("R13", 4'd1);
    wr("R13", 4'd4, 8'hFF); peek("R13", 4'd4);
    wr("R13", 4'd6, 8'h0F); peek("R13", 4'd6);
    wr("R13", 4'd8, 8'hFF); peek("R13", 4'd8);
    wr("R13", 4'd0, 8'hFF); wr("R13", 4'd9, 8'hFF); wr("R13", 4'd3, 8'hFF);
    peek("R13", 4'd0); peek("R13", 4'd9); peek("R13", 4'd3);
    peek("R13", 4'd12); peek("R13", 4'd10);

    // R1 single groups
    ev_timer = 2'b01; peek("R1", 4'd0); peek("R1", 4'd0); rd("R4", 4'd3); peek("R4", 4'd3);
    ev_txm = 1; peek("R1", 4'd0); peek("R1", 4'd9);
    addr = 4'd0; txfifo_wr = 1; cyc("R9"); peek("R9", 4'd9);
    // R1 per-bit modem enable: bit 1 event with only bit 0 enabled
    wr("R1", 4'd6, 8'h01);
    ev_modem = 4'b0010; peek("R1", 4'd0); peek("R1", 4'd5);
    ev_modem = 4'b0001; peek("R1", 4'd0); peek("R3", 4'd2);
    // R5 selective write-zero then read clear
    wr("R5", 4'd5, 8'h02); peek("R5", 4'd5); peek("R5", 4'd0);
    ev_modem = 4'b1100; peek("R5", 4'd5);
    rd("R5", 4'd5); peek("R5", 4'd5);
    wr("R5", 4'd6, 8'h0F);

    // R6 receive machine, partially enabled
    wr("R6", 4'd8, 8'h80);
    ev_rxm = 7'b0000011; peek("R6", 4'd7); peek("R1", 4'd0);
    ev_rxm = 7'b1000000; peek("R6", 4'd0);
    wr("R6", 4'd7, 8'h7F); peek("R6", 4'd7);
    rd("R6", 4'd7); peek("R6", 4'd7);
    wr("R6", 4'd8, 8'hFE);

    // R7 receive FIFO flag
    ev_rxfifo = 1; ev_rxm = 7'b0000100; peek("R7", 4'd7);
    rd("R7", 4'd7); peek("R7", 4'd7); peek("R7", 4'd2);
    addr = 4'd7; rxfifo_rd = 1; cyc("R7"); peek("R7", 4'd7);
    ev_rxfifo = 1; peek("R7", 4'd7);
    wr("R7", 4'd7, 8'hFE); peek("R7", 4'd7);
    wr("R7", 4'd7, 8'h00); peek("R7", 4'd7);

    // R8 transmit FIFO, identification read with and without higher source
    ev_txfifo = 1; peek("R8", 4'd2);
    rd("R8", 4'd2); peek("R8", 4'd9); peek("R8", 4'd2);
    ev_txfifo = 1; ev_timer = 2'b10; peek("R3", 4'd2);
    rd("R8", 4'd2); peek("R8", 4'd9);
    rd("R4", 4'd3); peek("R3", 4'd2);
    addr = 4'd9; txfifo_wr = 1; cyc("R8"); peek("R8", 4'd9);

    // R2 / R3 several groups under several masks
    ev_timer = 2'b11; ev_modem = 4'b0100; ev_rxm = 7'b0010000;
    ev_rxfifo = 1; ev_txfifo = 1; ev_txm = 1; peek("R3", 4'd2);
    peek("R1", 4'd0);
    wr("R2", 4'd1, 8'h1F); peek("R3", 4'd2);
    wr("R2", 4'd1, 8'h0C); peek("R3", 4'd2);
    wr("R2", 4'd1, 8'h01); peek("R3", 4'd2);
    wr("R2", 4'd1, 8'h00); peek("R2", 4'd2); peek("R2", 4'd0);
    wr("R2", 4'd1, 8'h3F); peek("R2", 4'd2);

    // R11 event together with clears
    ev_timer = 2'b01; rd("R11", 4'd3); peek("R11", 4'd3);
    ev_modem = 4'b0100; wr("R11", 4'd5, 8'h00); peek("R11", 4'd5);
    ev_txfifo = 1; txfifo_wr = 1; addr = 4'd9; cyc("R11"); peek("R11", 4'd9);

    // R10 global clear, enables kept; event in the same cycle survives
    wr("R10", 4'd10, 8'h00); peek("R10", 4'd0);
    ev_rxm = 7'b0000001; wr("R10", 4'd10, 8'h01);
    peek("R10", 4'd0); peek("R10", 4'd7); peek("R10", 4'd9); peek("R10", 4'd3);
    peek("R10", 4'd1); peek("R10", 4'd8);
    wr("R10", 4'd10, 8'h01); peek("R10", 4'd7); peek("R10", 4'd2);

    finish_run();
  end
endmodule